// File: doc/BRIEF.md
# Carry-Chain Equality Comparator

This block compares two operands of the same width and returns a single bit. A parameter fixes the polarity at elaboration time. In one setting the bit is high when the operands match. In the other setting it is high when they differ. The logic is purely combinational and has no clock or state. It is meant to sit inside a larger datapath, where tag matches, address hits and similar identity tests need a compact structure that maps well onto carry logic.

Narrow operands of one or two bits go through a single lookup function. Wider operands are split into two-bit groups, counted from bit 0. Each group feeds a slice that tests whether its bits match. That slice steers a mux stage:

- When the group matches, the stage forwards the value from the stage below.
- When the group differs, the stage forces a shared constant.

The "differ" polarity is not produced by an output inverter. It comes from exchanging the chain's constant data value and its seed value at the bottom of the chain. The slices are identical in both polarities.

Top module: `eqcmp_chain`

## Requirements
- R1: With a width of 1, `result` is the XNOR of `op_a[0]` and `op_b[0]` in match polarity (MODE = CMP_EQ, encoded 0), and their XOR in differ polarity (MODE = CMP_NE, encoded 1).
- R2: With a width of 2, `result` is 1 in match polarity exactly when both bit positions agree, and it is the complement of that in differ polarity.
- R3: For widths of 3 or more, bits are grouped in pairs starting at bit 0. When the width is odd, the most significant group holds only bit W-1, and that bit still takes part in the comparison.
- R4: When the operands are identical, `result` is 1 in match polarity and 0 in differ polarity, for every operand value.
- R5: A difference confined to any single bit position, including bit 0 and bit W-1, gives `result` 0 in match polarity and 1 in differ polarity.
- R6: For any operand pair, `result` equals (op_a == op_b) in match polarity and (op_a != op_b) in differ polarity.
- R7: When both operands carry no unknown bits, `result` is a known 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| result | output | 1 | Comparison outcome in the polarity chosen by MODE |

## Verification
The bench builds ten instances at the same time: widths 1, 2, 3, 8 and 9, each in both polarities. Each width reaches a different part of the block:

- Widths 1 and 2 exercise the single-lookup path.
- Width 8 exercises a chain made only of full pairs.
- Widths 3 and 9 exercise a chain that ends in a lone top bit.

Using both polarities at every width shows that swapping the chain constants inverts the outcome at every depth. Walking a single-bit difference across all positions reaches the bottom seed and the top stage on each instance.

// File: rtl/eqcmp_pkg.sv
package eqcmp_pkg;

    typedef enum logic {
        CMP_EQ = 1'b0,
        CMP_NE = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic pass;   // slice reports its bits match
        logic lower;  // value coming up from the stage below
    } stage_in_t;

    // Value a stage forces when its slice sees a mismatch.
    function automatic logic chain_data_const(cmp_mode_e mode);
        return (mode == CMP_NE);
    endfunction

    // Value fed into the lowest stage as its incoming carry.
    function automatic logic chain_seed(cmp_mode_e mode);
        return (mode == CMP_EQ);
    endfunction

    // Pairwise equality over one or two bit positions.
    function automatic logic pair_match(logic [1:0] a, logic [1:0] b, logic use_hi);
        logic lo_ok;
        logic hi_ok;
        lo_ok = ~(a[0] ^ b[0]);
        hi_ok = use_hi ? ~(a[1] ^ b[1]) : 1'b1;
        return lo_ok & hi_ok;
    endfunction

endpackage

// File: rtl/eqcmp_slice.sv
module eqcmp_slice
    import eqcmp_pkg::*;
#(
    parameter int PAIR_BITS = 2
) (
    input  logic [PAIR_BITS-1:0] sa,
    input  logic [PAIR_BITS-1:0] sb,
    output logic                 match
);
    logic [1:0] pa;
    logic [1:0] pb;

    generate
        if (PAIR_BITS == 2) begin : g_two
            assign pa = sa;
            assign pb = sb;
        end else begin : g_one
            assign pa = {1'b0, sa[0]};
            assign pb = {1'b0, sb[0]};
        end
    endgenerate

    assign match = pair_match(pa, pb, PAIR_BITS == 2);
endmodule

// File: rtl/eqcmp_stage.sv
module eqcmp_stage
    import eqcmp_pkg::*;
(
    input  stage_in_t sin,
    input  logic      dconst,
    output logic      sout
);
    always_comb begin
        if (sin.pass) sout = sin.lower;
        else          sout = dconst;
    end
endmodule

// File: rtl/eqcmp_lut.sv
module eqcmp_lut
    import eqcmp_pkg::*;
#(
    parameter int        W    = 2,
    parameter cmp_mode_e MODE = CMP_EQ
) (
    input  logic [W-1:0] la,
    input  logic [W-1:0] lb,
    output logic         lout
);
    logic hit;

    generate
        if (W == 2) begin : g_w2
            assign hit = pair_match(la, lb, 1'b1);
        end else begin : g_w1
            assign hit = pair_match({1'b0, la[0]}, {1'b0, lb[0]}, 1'b0);
        end
    endgenerate

    assign lout = (MODE == CMP_NE) ? ~hit : hit;
endmodule

// File: rtl/eqcmp_chain.sv
module eqcmp_chain
    import eqcmp_pkg::*;
#(
    parameter int        W    = 8,
    parameter cmp_mode_e MODE = CMP_EQ
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         result
);
    localparam int N_SLICES = (W + 1) / 2;
    localparam bit USE_LUT  = (W <= 2);

    generate
        if (USE_LUT) begin : g_lut
            eqcmp_lut #(.W(W), .MODE(MODE)) u_lut (
                .la   (op_a),
                .lb   (op_b),
                .lout (result)
            );
        end else begin : g_chain
            logic [N_SLICES:0]   carry;
            logic [N_SLICES-1:0] match;
            logic                dconst;

            assign carry[0] = chain_seed(MODE);
            assign dconst   = chain_data_const(MODE);

            for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
                localparam int PW = ((2 * k + 1) < W) ? 2 : 1;
                stage_in_t sin;

                eqcmp_slice #(.PAIR_BITS(PW)) u_slice (
                    .sa    (op_a[2*k +: PW]),
                    .sb    (op_b[2*k +: PW]),
                    .match (match[k])
                );

                assign sin.pass  = match[k];
                assign sin.lower = carry[k];

                eqcmp_stage u_stage (
                    .sin    (sin),
                    .dconst (dconst),
                    .sout   (carry[k+1])
                );
            end

            assign result = carry[N_SLICES];
        end
    endgenerate
endmodule

// File: rtl/eqcmp_chain_chk.sv
module eqcmp_chain_chk
    import eqcmp_pkg::*;
#(
    parameter int        W    = 8,
    parameter cmp_mode_e MODE = CMP_EQ
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         result
);
    logic known_in;
    logic ne_val;

    assign known_in = !$isunknown({op_a, op_b});
    assign ne_val   = (MODE == CMP_NE);

    always_comb begin
        if (known_in) begin
            AST_RESULT_KNOWN: assert (!$isunknown(result)) else $error("unknown result"); // R7
            AST_POLARITY_MATCH: assert (result == ((op_a == op_b) ^ ne_val)) else $error("polarity mismatch"); // R6
            if (op_a == op_b) begin
                AST_SAME_OPERANDS: assert (result == ~ne_val) else $error("equal operands wrong"); // R4
            end
            if (op_a[0] != op_b[0]) begin
                AST_LSB_DIFF: assert (result == ne_val) else $error("bit 0 difference missed"); // R5
            end
            if (op_a[W-1] != op_b[W-1]) begin
                AST_MSB_DIFF: assert (result == ne_val) else $error("top bit difference missed"); // R3
            end
        end
    end
endmodule

bind eqcmp_chain eqcmp_chain_chk #(.W(W), .MODE(MODE)) u_chk (
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result)
);

// File: tb/eqcmp_chain_test.sv
module eqcmp_chain_test;
    import eqcmp_pkg::*;

    localparam int NW = 5;
    localparam int WS [NW] = '{1, 2, 3, 8, 9};
    localparam int MAXW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [MAXW-1:0] a_in = '0;
    logic [MAXW-1:0] b_in = '0;
    logic [1:0]      res [NW];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    for (genvar i = 0; i < NW; i++) begin : g_w
        for (genvar m = 0; m < 2; m++) begin : g_m
            eqcmp_chain #(.W(WS[i]), .MODE(cmp_mode_e'(m))) uut (
                .op_a   (a_in[WS[i]-1:0]),
                .op_b   (b_in[WS[i]-1:0]),
                .result (res[i][m])
            );
        end
    end

    function automatic logic ref_out(int w, int ne, logic [MAXW-1:0] a, logic [MAXW-1:0] b);
        logic [MAXW-1:0] mask;
        mask = '0;
        for (int k = 0; k < w; k++) mask[k] = 1'b1;
        return (((a ^ b) & mask) == '0) ? (ne == 0) : (ne != 0);
    endfunction

    function automatic string req_for(int w, string dflt);
        if (w == 1) return "R1";
        if (w == 2) return "R2";
        if (w % 2 == 1) return "R3";
        return dflt;
    endfunction

    task automatic check_all(string req);
        for (int i = 0; i < NW; i++) begin
            for (int m = 0; m < 2; m++) begin
                logic exp_v;
                string tag;
                exp_v = ref_out(WS[i], m, a_in, b_in);
                tag = (req == "R6") ? req_for(WS[i], req) : req;
                n_tests++;
                if ($isunknown(res[i][m])) begin
                    n_fail++;
                    $display("FAIL R7 W=%0d mode=%0d actual=%b expected=%b", WS[i], m, res[i][m], exp_v);
                end else if (res[i][m] !== exp_v) begin
                    n_fail++;
                    $display("FAIL %s W=%0d mode=%0d a=%h b=%h actual=%b expected=%b",
                             tag, WS[i], m, a_in, b_in, res[i][m], exp_v);
                end
            end
        end
    endtask

    task automatic apply(logic [MAXW-1:0] a, logic [MAXW-1:0] b, string req);
        @(posedge clk);
        a_in = a;
        b_in = b;
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R4");  // reset-time state: zero operands, equal
        // R4: identical operands
        for (int v = 0; v < 40; v++) begin
            logic [MAXW-1:0] x;
            x = MAXW'($urandom);
            apply(x, x, "R4");
        end
        apply('1, '1, "R4");
        // R5: single-bit difference at every position
        for (int p = 0; p < MAXW; p++) begin
            logic [MAXW-1:0] x;
            x = MAXW'($urandom);
            apply(x, x ^ (MAXW'(1) << p), "R5");
        end
        // R1/R2: exhaustive low two bits
        for (int v = 0; v < 16; v++) begin
            apply(MAXW'(v[1:0]), MAXW'(v[3:2]), "R6");
        end
        // R3: only the top bit of the odd widths differs
        apply(9'h000, 9'h004, "R3");
        apply(9'h0FF, 9'h1FF, "R3");
        // R6: random pairs, with many near-equal cases
        for (int v = 0; v < 300; v++) begin
            logic [MAXW-1:0] x;
            logic [MAXW-1:0] y;
            x = MAXW'($urandom);
            y = ($urandom_range(0, 1) == 1) ? x ^ MAXW'($urandom_range(0, 3)) : MAXW'($urandom);
            apply(x, y, "R6");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule